// File: doc/BRIEF.md
# Masked Slave Address Recognizer

This block sits beside the shift register of a two-wire serial bus controller. When a complete address byte has been shifted in, the block compares the byte's upper seven bits with a programmed address. A per-bit care mask takes part in that comparison, so one address/mask pair can select a single address or a whole range. The all-zero broadcast address can be accepted on its own, whatever the address and mask hold. The block keeps the compare result and the received direction bit until the bus frame ends. It also supplies the level to put on the acknowledge bit.

A single hardware-acknowledge enable turns on two things at once: the address recognition and the automatic acknowledge of received data bytes. With the enable low, the acknowledge level is the software-supplied value and recognition stays off. Bit sampling and clock timing belong to the surrounding controller.

Top module: `smb_addr_match`

## Requirements
- R1: After reset `addr_match` and `rx_rw` are 0. With `hw_ack_en` high, `ack_out` is 0, which means SDA is released (NACK).
- R2: With `hw_ack_en` high, an address byte is matched only if every received address bit `rx_byte[7:1]` whose `slv_mask` bit is 1 equals the corresponding `slv_addr` bit.
- R3: Received address bits whose `slv_mask` bit is 0 are don't-care and never prevent a match.
- R4: With `gc_en` high, the received address 0x00 is matched regardless of `slv_addr` and `slv_mask`. With `gc_en` low, 0x00 matches only through the normal masked compare.
- R5: `rx_byte[0]` is the read/write direction. It takes no part in the compare and appears on `rx_rw` one cycle after an address byte is accepted.
- R6: An address byte is accepted when `byte_vld` and `addr_phase` are both high. Its result appears on `addr_match` at the next cycle and is held until `start_det` or `stop_det`. Either of those clears the result in the next cycle, and takes priority over an address byte in the same cycle.
- R7: With `hw_ack_en` low, `ack_out` follows `sw_ack` combinationally and `addr_match` stays 0.
- R8: With `hw_ack_en` high, `ack_out` is 1 (drive SDA low) after a matching address byte and 0 (release) after a non-matching one.
- R9: With `hw_ack_en` high, a data byte (`byte_vld` high, `addr_phase` low) sets `ack_out` to 1 and leaves `addr_match` unchanged.
- R10: `start_det` or `stop_det` returns the hardware acknowledge level to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | START or repeated START seen (one-cycle pulse) |
| stop_det | input | 1 | STOP seen (one-cycle pulse) |
| byte_vld | input | 1 | A full byte is present on rx_byte (one-cycle pulse) |
| addr_phase | input | 1 | The present byte is the address byte |
| rx_byte | input | 8 | Shifted-in byte; bits 7:1 address, bit 0 direction |
| slv_addr | input | 7 | Programmed slave address |
| slv_mask | input | 7 | Care mask, 1 = bit compared |
| gc_en | input | 1 | Accept broadcast address 0x00 |
| hw_ack_en | input | 1 | Enable recognition and automatic acknowledge |
| sw_ack | input | 1 | Software acknowledge level, 1 = ACK |
| addr_match | output | 1 | Held address match result |
| rx_rw | output | 1 | Held direction bit of the last address byte |
| ack_out | output | 1 | Acknowledge level, 1 = pull SDA low |

## Verification
The bench covers the following corner cases:
- Addresses that differ from the programmed address only in masked-out bits. A design that ignored the mask would NACK them.
- Addresses that differ only in a cared bit. A design with the mask inverted would wrongly ACK them.
- The broadcast address with the broadcast enable both on and off. This catches a broadcast match that leaks through when disabled.
- Address bytes with only the direction bit changed, which exposes a direction bit that takes part in the compare.
- An address byte that arrives in the same cycle as a START. A wrong priority there would leave a stale match standing.
- The software acknowledge path with the enable low.

// File: rtl/smb_addr_pkg.sv
package smb_addr_pkg;

    typedef struct packed {
        logic match;   // held compare result
        logic rw;      // held direction bit
        logic ack_hw;  // hardware acknowledge level
    } amr_state_t;

    localparam amr_state_t AMR_RESET = '{match: 1'b0, rw: 1'b0, ack_hw: 1'b0};

endpackage

// File: rtl/smb_addr_cmp.sv
module smb_addr_cmp #(
    parameter int AW = 7
) (
    input  logic [AW-1:0] rx_addr,
    input  logic [AW-1:0] slv_addr,
    input  logic [AW-1:0] slv_mask,
    input  logic          gc_en,
    output logic          hit
);
    logic [AW-1:0] bit_bad;

    // per-bit mismatch, only where the mask cares
    for (genvar i = 0; i < AW; i++) begin : g_bit
        assign bit_bad[i] = slv_mask[i] & (rx_addr[i] ^ slv_addr[i]);
    end

    logic masked_ok;
    logic gc_ok;

    always_comb begin
        masked_ok = ~|bit_bad;
        gc_ok     = gc_en & ~|rx_addr;
        hit       = masked_ok | gc_ok;
    end

    always_comb begin
        if (gc_en && rx_addr == '0) begin
            a_gc_r4: assert (hit);
        end
    end
endmodule

// File: rtl/smb_ack_ctrl.sv
module smb_ack_ctrl (
    input  logic hw_ack_en,
    input  logic sw_ack,
    input  logic ack_hw_q,
    output logic ack_out
);
    always_comb begin
        if (hw_ack_en) begin
            ack_out = ack_hw_q;
        end else begin
            ack_out = sw_ack;
        end
    end
endmodule

// File: rtl/smb_addr_match.sv
module smb_addr_match
    import smb_addr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int AW    = BYTE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              byte_vld,
    input  logic              addr_phase,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [AW-1:0]     slv_addr,
    input  logic [AW-1:0]     slv_mask,
    input  logic              gc_en,
    input  logic              hw_ack_en,
    input  logic              sw_ack,
    output logic              addr_match,
    output logic              rx_rw,
    output logic              ack_out
);
    amr_state_t st_d, st_q;
    logic       cmp_hit;
    logic       frame_edge;
    logic       addr_take;
    logic       data_take;

    smb_addr_cmp #(.AW(AW)) i_cmp (
        .rx_addr  (rx_byte[BYTE_W-1:1]),
        .slv_addr (slv_addr),
        .slv_mask (slv_mask),
        .gc_en    (gc_en),
        .hit      (cmp_hit)
    );

    smb_ack_ctrl i_ack (
        .hw_ack_en (hw_ack_en),
        .sw_ack    (sw_ack),
        .ack_hw_q  (st_q.ack_hw),
        .ack_out   (ack_out)
    );

    always_comb begin
        frame_edge = start_det | stop_det;
        addr_take  = byte_vld & addr_phase & ~frame_edge;
        data_take  = byte_vld & ~addr_phase & ~frame_edge;
        st_d       = st_q;
        if (frame_edge) begin
            st_d.match  = 1'b0;
            st_d.ack_hw = 1'b0;
        end else if (addr_take) begin
            st_d.match  = hw_ack_en & cmp_hit;
            st_d.rw     = rx_byte[0];
            st_d.ack_hw = hw_ack_en & cmp_hit;
        end else if (data_take) begin
            st_d.ack_hw = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= AMR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_match = st_q.match;
    assign rx_rw      = st_q.rw;

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> (!addr_match && !st_q.ack_hw));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_det && !stop_det && !(byte_vld && addr_phase)) |=> $stable(addr_match));

    p_rw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && addr_phase && !start_det && !stop_det) |=> (rx_rw == $past(rx_byte[0])));

    p_data_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !addr_phase && hw_ack_en && !start_det && !stop_det) |=> st_q.ack_hw);

    p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && addr_phase && !hw_ack_en) |=> !addr_match);
endmodule

// File: tb/test_smb_addr_match.sv
module test_smb_addr_match;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_det = 1'b0, stop_det = 1'b0, byte_vld = 1'b0, addr_phase = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [6:0] slv_addr = '0, slv_mask = '0;
    logic       gc_en = 1'b0, hw_ack_en = 1'b0, sw_ack = 1'b0;
    logic       addr_match, rx_rw, ack_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_addr_match i_smb_addr_match (
        .clk, .rst_n, .start_det, .stop_det, .byte_vld, .addr_phase, .rx_byte,
        .slv_addr, .slv_mask, .gc_en, .hw_ack_en, .sw_ack,
        .addr_match, .rx_rw, .ack_out
    );

    typedef struct {
        logic  match;
        logic  rw;
        logic  ack;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    logic m_match = 0, m_rw = 0, m_ackhw = 0;
    bit   done = 0;

    // reference model, written from the requirements
    function automatic logic want_hit(logic [7:0] b);
        logic cared_ok;
        cared_ok = 1'b1;
        for (int i = 0; i < 7; i++) begin
            if (slv_mask[i] && (b[i+1] != slv_addr[i])) cared_ok = 1'b0;
        end
        return hw_ack_en && (cared_ok || (gc_en && b[7:1] == 7'd0));
    endfunction

    task automatic push(string tag);
        exp_t e;
        e.match = m_match;
        e.rw    = m_rw;
        e.ack   = hw_ack_en ? m_ackhw : sw_ack;
        e.tag   = tag;
        q.push_back(e);
    endtask

    task automatic send(logic ap, logic [7:0] b, logic with_start, string tag);
        @(negedge clk);
        byte_vld = 1; addr_phase = ap; rx_byte = b; start_det = with_start;
        if (with_start) begin
            m_match = 0; m_ackhw = 0;
        end else if (ap) begin
            m_match = want_hit(b); m_rw = b[0]; m_ackhw = want_hit(b);
        end else if (hw_ack_en) begin
            m_ackhw = 1;
        end else begin
            m_ackhw = 1;
        end
        @(negedge clk);
        byte_vld = 0; addr_phase = 0; start_det = 0;
        push(tag);
        @(negedge clk);
    endtask

    task automatic cond(logic is_stop, string tag);
        @(negedge clk);
        if (is_stop) stop_det = 1; else start_det = 1;
        m_match = 0; m_ackhw = 0;
        @(negedge clk);
        stop_det = 0; start_det = 0;
        push(tag);
        @(negedge clk);
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        push(tag);
        @(negedge clk);
    endtask

    // monitor: pops expected items and compares just after the falling edge
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (addr_match !== e.match || rx_rw !== e.rw || ack_out !== e.ack) begin
                n_errors++;
                $display("FAIL %s: actual match=%b rw=%b ack=%b expected match=%b rw=%b ack=%b",
                         e.tag, addr_match, rx_rw, ack_out, e.match, e.rw, e.ack);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        hw_ack_en = 1; slv_addr = 7'h50; slv_mask = 7'h7F;
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle("R1 reset state");

        send(1, 8'hA1, 0, "R2 R5 R8 exact match read");
        send(0, 8'h3C, 0, "R9 data byte auto ack");
        cond(1, "R10 R6 stop clears");
        send(1, 8'hA3, 0, "R2 R8 cared bit differs");
        send(1, 8'hA0, 0, "R5 direction bit ignored");
        slv_mask = 7'h7C;
        send(1, 8'hA6, 0, "R3 low bits dont care");
        send(1, 8'hA8, 0, "R3 cared bit2 differs");
        cond(0, "R10 start clears");
        gc_en = 1;
        send(1, 8'h00, 0, "R4 general call enabled");
        idle("R6 match held");
        send(0, 8'h11, 0, "R9 data keeps match");
        cond(0, "R6 start before gc off");
        gc_en = 0; slv_mask = 7'h7F;
        send(1, 8'h00, 0, "R4 general call disabled");
        send(1, 8'hA0, 0, "R6 rematch");
        send(1, 8'hA1, 1, "R6 start wins over byte");
        hw_ack_en = 0; sw_ack = 1;
        send(1, 8'hA0, 0, "R7 no recognition, sw ack 1");
        sw_ack = 0;
        idle("R7 sw ack 0");
        sw_ack = 1;
        idle("R7 sw ack back to 1");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule